// File: doc/BRIEF.md
# Single-Cycle Register-Machine Processor Core

This block is a small processor core that completes one 32-bit instruction per clock. It holds an 11-bit program counter, a 32-entry by 32-bit register file and a 2048-word data memory. The ALU covers arithmetic, shifts, logical operations and comparisons. The core also has a register move, an indexed load and store, a load-immediate, a jump to a register and a branch that is taken when a register is zero. It has halt and no-op instructions, and two I/O instructions: one reads an 11-bit switch bank, and the other drives a 32-bit display register and a sign lamp.

Instructions are read through a combinational fetch port. The core puts out the program counter and expects the addressed word back in the same cycle. I/O instructions wait for a manual step. While an I/O instruction is current, the core holds the program counter and writes nothing. On a clock edge where the step input is high, the I/O action commits and execution moves on. Software should place a no-op after every I/O instruction.

Top module: `cpu_core`

## Requirements
- R1: A synchronous active-high reset clears the program counter, every register, the display register and the sign lamp.
- R2: The instruction fields are opcode [31:26], destination index [25:21], first source index [20:16], second source index [15:11] and an 11-bit immediate [10:0]. Opcodes 0 to 13 write f(A,B) into the register named by [25:21], where A and B are the registers named by [20:16] and [15:11]:
  - 0 add, 1 subtract, 2 multiply (low 32 bits), 3 unsigned divide, 4 unsigned remainder (both give 0 when B is 0).
  - 5 shift A left by B and 6 shift A right (logical) by B, both giving 0 when B is 32 or more.
  - 7 logical AND and 8 logical OR, each returning 0 or 1.
  - 9 gives 1 when A is zero and 0 otherwise.
  - 10 equal, 11 not equal, 12 unsigned less-than and 13 unsigned less-or-equal, each returning 0 or 1.
- R3: Opcode 14 copies the register at [15:11] into the register at [20:16] and leaves the register at [25:21] unchanged.
- R4: Opcode 16 stores the register at [20:16] to the data word at the address formed by adding the register at [15:11] and the 11-bit immediate. Opcode 15 loads the data word at that address into the register at [25:21]. Only the low 11 bits of the sum are used, so the address wraps.
- R5: Opcode 17 writes bits [20:0] of the instruction, zero-extended to 32 bits, into the register at [25:21].
- R6: Opcode 18 writes the 11 switch bits, zero-extended, into the register at [25:21]. The switches are sampled on the clock edge where the step input is high.
- R7: On a step, opcode 19 loads the register at [20:16] into the display output and copies its bit 31 onto the sign lamp. Nothing else changes either output.
- R8: While opcode 18 or 19 is current and the step input is low, the program counter is held and neither a register nor the display changes.
- R9: Opcode 20 sets the program counter to the low 11 bits of the register at [20:16].
- R10: Opcode 21 jumps to the low 11 bits of the register at [20:16] when the register at [15:11] is zero. Otherwise it advances to the next instruction.
- R11: Opcode 22 holds the program counter. Opcode 23, every other non-control opcode and every undefined opcode (24 to 63) advance it by one. An undefined opcode writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 11 | Program counter, used as the fetch address |
| imem_word | input | 32 | Instruction word at imem_addr, same cycle |
| sw_in | input | 11 | Switch bank read by the input instruction |
| step_pulse | input | 1 | Manual step that completes an I/O instruction |
| disp_out | output | 32 | Display register |
| sign_led | output | 1 | Sign lamp, bit 31 of the last displayed value |

## Verification
On every cycle the assertions check the control flow that can be seen at the ports. A pending I/O instruction or a halt must keep the fetch address fixed, and a no-op must advance it by exactly one. The display and lamp may change only on a stepped output instruction, the lamp always equals the display's top bit, and reset returns both outputs and the fetch address to zero. Datapath results cannot be seen cycle by cycle, because register contents stay hidden until an output instruction exposes them. This covers each ALU opcode, the move, address wrap in load and store, zero-extension, jump targets and both branch outcomes, and only the bench's small programs can show them.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

    localparam int XLEN     = 32;
    localparam int REG_CNT  = 32;
    localparam int REG_AW   = $clog2(REG_CNT);
    localparam int PC_W     = 11;
    localparam int OPC_W    = 6;
    localparam int IMM_S_W  = 11;
    localparam int IMM_L_W  = 21;
    localparam int SW_W     = 11;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD  = 6'd0,  OP_SUB  = 6'd1,  OP_MUL  = 6'd2,  OP_DIV  = 6'd3,
        OP_MOD  = 6'd4,  OP_SHL  = 6'd5,  OP_SHR  = 6'd6,  OP_LAND = 6'd7,
        OP_LOR  = 6'd8,  OP_LNOT = 6'd9,  OP_CEQ  = 6'd10, OP_CNE  = 6'd11,
        OP_CLT  = 6'd12, OP_CLE  = 6'd13, OP_MOV  = 6'd14, OP_LD   = 6'd15,
        OP_ST   = 6'd16, OP_LDI  = 6'd17, OP_IN   = 6'd18, OP_OUT  = 6'd19,
        OP_JMP  = 6'd20, OP_BRZ  = 6'd21, OP_HALT = 6'd22, OP_NOP  = 6'd23
    } opcode_e;

    typedef struct packed {
        logic [OPC_W-1:0]   opc;
        logic [REG_AW-1:0]  rs;
        logic [REG_AW-1:0]  rt;
        logic [REG_AW-1:0]  rd;
        logic [IMM_S_W-1:0] imm;
    } instr_t;

    typedef enum logic [2:0] {
        WB_ALU, WB_MOVE, WB_MEM, WB_IMM, WB_SWITCH
    } wb_sel_e;

    typedef enum logic [1:0] {
        NPC_INC, NPC_HOLD, NPC_JUMP, NPC_BRZ
    } npc_sel_e;

    typedef struct packed {
        logic              rf_we;
        logic [REG_AW-1:0] rf_waddr;
        wb_sel_e           wb_sel;
        logic              dm_we;
        logic              is_io;
        logic              disp_load;
        npc_sel_e          npc_sel;
    } ctrl_t;

    function automatic logic [IMM_L_W-1:0] long_imm(instr_t i);
        return {i.rt, i.rd, i.imm};
    endfunction

    function automatic ctrl_t decode(instr_t i);
        ctrl_t c;
        c.rf_we     = 1'b0;
        c.rf_waddr  = i.rs;
        c.wb_sel    = WB_ALU;
        c.dm_we     = 1'b0;
        c.is_io     = 1'b0;
        c.disp_load = 1'b0;
        c.npc_sel   = NPC_INC;
        if (i.opc <= OP_CLE) begin
            c.rf_we = 1'b1;
        end else begin
            case (i.opc)
                OP_MOV: begin
                    c.rf_we    = 1'b1;
                    c.rf_waddr = i.rt;
                    c.wb_sel   = WB_MOVE;
                end
                OP_LD: begin
                    c.rf_we  = 1'b1;
                    c.wb_sel = WB_MEM;
                end
                OP_ST:   c.dm_we = 1'b1;
                OP_LDI: begin
                    c.rf_we  = 1'b1;
                    c.wb_sel = WB_IMM;
                end
                OP_IN: begin
                    c.rf_we  = 1'b1;
                    c.wb_sel = WB_SWITCH;
                    c.is_io  = 1'b1;
                end
                OP_OUT: begin
                    c.is_io     = 1'b1;
                    c.disp_load = 1'b1;
                end
                OP_JMP:  c.npc_sel = NPC_JUMP;
                OP_BRZ:  c.npc_sel = NPC_BRZ;
                OP_HALT: c.npc_sel = NPC_HOLD;
                default: ;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/cpu_alu.sv
module cpu_alu
    import cpu_pkg::*;
#(
    parameter int DW = XLEN
) (
    input  logic [OPC_W-1:0] opc,
    input  logic [DW-1:0]    a,
    input  logic [DW-1:0]    b,
    output logic [DW-1:0]    y
);
    localparam logic [DW-1:0] ONE = DW'(1);
    localparam logic [DW-1:0] ZERO = '0;

    logic b_zero;
    assign b_zero = (b == ZERO);

    always_comb begin
        case (opc)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_MUL:  y = a * b;
            OP_DIV:  y = b_zero ? ZERO : a / b;
            OP_MOD:  y = b_zero ? ZERO : a % b;
            OP_SHL:  y = a << b;
            OP_SHR:  y = a >> b;
            OP_LAND: y = ((a != ZERO) && !b_zero) ? ONE : ZERO;
            OP_LOR:  y = ((a != ZERO) || !b_zero) ? ONE : ZERO;
            OP_LNOT: y = (a == ZERO) ? ONE : ZERO;
            OP_CEQ:  y = (a == b) ? ONE : ZERO;
            OP_CNE:  y = (a != b) ? ONE : ZERO;
            OP_CLT:  y = (a < b)  ? ONE : ZERO;
            OP_CLE:  y = (a <= b) ? ONE : ZERO;
            default: y = ZERO;
        endcase
    end
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
    parameter int DW  = 32,
    parameter int CNT = 32,
    parameter int AW  = $clog2(CNT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_addr,
    input  logic [AW-1:0] rb_addr,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd,
    output logic [DW-1:0] ra_data,
    output logic [DW-1:0] rb_data
);
    logic [DW-1:0] regs [CNT];

    assign ra_data = regs[ra_addr];
    assign rb_data = regs[rb_addr];

    generate
        for (genvar g = 0; g < CNT; g++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)
                    regs[g] <= '0;
                else if (we && (wa == AW'(g)))
                    regs[g] <= wd;
            end
        end
    endgenerate
endmodule

// File: rtl/cpu_datamem.sv
module cpu_datamem #(
    parameter int DW    = 32,
    parameter int DEPTH = 2048,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    assign rdata = mem[addr];

    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
    end
endmodule

// File: rtl/cpu_core.sv
module cpu_core
    import cpu_pkg::*;
#(
    parameter int DMEM_WORDS = 2048
) (
    input  logic              clk,
    input  logic              rst,
    output logic [PC_W-1:0]   imem_addr,
    input  logic [XLEN-1:0]   imem_word,
    input  logic [SW_W-1:0]   sw_in,
    input  logic              step_pulse,
    output logic [XLEN-1:0]   disp_out,
    output logic              sign_led
);
    localparam int DM_AW = $clog2(DMEM_WORDS);

    instr_t            ins;
    ctrl_t             ctl;
    logic [PC_W-1:0]   pc_q;
    logic [PC_W-1:0]   pc_nxt;
    logic [PC_W-1:0]   pc_inc;
    logic [XLEN-1:0]   rt_val;
    logic [XLEN-1:0]   rd_val;
    logic [XLEN-1:0]   alu_y;
    logic [XLEN-1:0]   dm_rdata;
    logic [XLEN-1:0]   wb_data;
    logic [DM_AW-1:0]  dm_addr;
    logic              commit;

    assign ins       = instr_t'(imem_word);
    assign ctl       = decode(ins);
    assign imem_addr = pc_q;
    assign pc_inc    = pc_q + PC_W'(1);
    assign commit    = !ctl.is_io || step_pulse;
    assign dm_addr   = rd_val[DM_AW-1:0] + DM_AW'(ins.imm);

    cpu_regfile #(
        .DW  (XLEN),
        .CNT (REG_CNT)
    ) i_regs (
        .clk     (clk),
        .rst     (rst),
        .ra_addr (ins.rt),
        .rb_addr (ins.rd),
        .we      (ctl.rf_we && commit),
        .wa      (ctl.rf_waddr),
        .wd      (wb_data),
        .ra_data (rt_val),
        .rb_data (rd_val)
    );

    cpu_alu #(
        .DW (XLEN)
    ) i_alu (
        .opc (ins.opc),
        .a   (rt_val),
        .b   (rd_val),
        .y   (alu_y)
    );

    cpu_datamem #(
        .DW    (XLEN),
        .DEPTH (DMEM_WORDS)
    ) i_dmem (
        .clk   (clk),
        .we    (ctl.dm_we),
        .addr  (dm_addr),
        .wdata (rt_val),
        .rdata (dm_rdata)
    );

    always_comb begin
        case (ctl.wb_sel)
            WB_MOVE:   wb_data = rd_val;
            WB_MEM:    wb_data = dm_rdata;
            WB_IMM:    wb_data = XLEN'(long_imm(ins));
            WB_SWITCH: wb_data = XLEN'(sw_in);
            default:   wb_data = alu_y;
        endcase
    end

    always_comb begin
        case (ctl.npc_sel)
            NPC_HOLD: pc_nxt = pc_q;
            NPC_JUMP: pc_nxt = rt_val[PC_W-1:0];
            NPC_BRZ:  pc_nxt = (rd_val == '0) ? rt_val[PC_W-1:0] : pc_inc;
            default:  pc_nxt = pc_inc;
        endcase
        if (!commit)
            pc_nxt = pc_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= '0;
            disp_out <= '0;
            sign_led <= 1'b0;
        end else begin
            pc_q <= pc_nxt;
            if (ctl.disp_load && commit) begin
                disp_out <= rt_val;
                sign_led <= rt_val[XLEN-1];
            end
        end
    end
endmodule

// File: rtl/cpu_core_chk.sv
module cpu_core_chk
    import cpu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [PC_W-1:0]   imem_addr,
    input logic [OPC_W-1:0]  opc,
    input logic              step_pulse,
    input logic [XLEN-1:0]   disp_out,
    input logic              sign_led
);
    logic io_op;
    assign io_op = (opc == OP_IN) || (opc == OP_OUT);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (imem_addr == '0 && disp_out == '0 && !sign_led));

    // R8
    io_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (io_op && !step_pulse) |=> (imem_addr == $past(imem_addr)));

    // R7
    disp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(opc == OP_OUT && step_pulse) |=> ($stable(disp_out) && $stable(sign_led)));

    // R7
    lamp_sign_chk: assert property (@(posedge clk) disable iff (rst)
        sign_led == disp_out[XLEN-1]);

    // R11
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (opc == OP_HALT) |=> (imem_addr == $past(imem_addr)));

    // R11
    nop_step_chk: assert property (@(posedge clk) disable iff (rst)
        (opc == OP_NOP) |=> (imem_addr == $past(imem_addr) + PC_W'(1)));
endmodule

bind cpu_core cpu_core_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .opc        (imem_word[31:26]),
    .step_pulse (step_pulse),
    .disp_out   (disp_out),
    .sign_led   (sign_led)
);

// File: tb/test_cpu_core.sv
`timescale 1ns/1ps
module test_cpu_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] imem_addr;
    logic [31:0] imem_word;
    logic [10:0] sw_in = '0;
    logic        step_pulse = 1'b0;
    logic [31:0] disp_out;
    logic        sign_led;

    int checks = 0;
    int errors = 0;
    logic [31:0] prog [64];

    always #4 clk = ~clk;

    always_comb imem_word = (imem_addr < 11'd64) ? prog[imem_addr[5:0]] : {6'd22, 26'd0};

    cpu_core i_cpu_core (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_word  (imem_word),
        .sw_in      (sw_in),
        .step_pulse (step_pulse),
        .disp_out   (disp_out),
        .sign_led   (sign_led)
    );

    typedef struct packed {
        logic [5:0]  op;
        logic [20:0] a;
        logic [20:0] b;
        logic [31:0] y;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{6'd0,  21'd100000,  21'd23456,   32'h0001E240},
        '{6'd1,  21'd5,       21'd7,       32'hFFFFFFFE},
        '{6'd2,  21'd1000,    21'd2000,    32'd2000000},
        '{6'd2,  21'h1FFFFF,  21'h1FFFFF,  32'hFFC00001},
        '{6'd3,  21'd1000,    21'd7,       32'd142},
        '{6'd3,  21'd1000,    21'd0,       32'd0},
        '{6'd4,  21'd1000,    21'd7,       32'd6},
        '{6'd4,  21'd1000,    21'd0,       32'd0},
        '{6'd5,  21'd1,       21'd31,      32'h80000000},
        '{6'd5,  21'd3,       21'd40,      32'd0},
        '{6'd6,  21'h100000,  21'd20,      32'd1},
        '{6'd7,  21'd5,       21'd0,       32'd0},
        '{6'd7,  21'd5,       21'd9,       32'd1},
        '{6'd8,  21'd0,       21'd0,       32'd0},
        '{6'd8,  21'd0,       21'd4,       32'd1},
        '{6'd9,  21'd0,       21'd3,       32'd1},
        '{6'd9,  21'd7,       21'd0,       32'd0},
        '{6'd10, 21'd9,       21'd9,       32'd1},
        '{6'd11, 21'd9,       21'd9,       32'd0},
        '{6'd12, 21'd3,       21'd4,       32'd1},
        '{6'd12, 21'd4,       21'd3,       32'd0},
        '{6'd13, 21'd4,       21'd4,       32'd1},
        '{6'd13, 21'd5,       21'd4,       32'd0},
        '{6'd11, 21'd2,       21'd9,       32'd1}
    };

    function automatic logic [31:0] enc(int op, int rs, int rt, int rd, int imm);
        return {op[5:0], rs[4:0], rt[4:0], rd[4:0], imm[10:0]};
    endfunction

    function automatic logic [31:0] ldi(int rs, int imm);
        return {6'd17, rs[4:0], imm[20:0]};
    endfunction

    localparam logic [31:0] NOPW = {6'd23, 26'd0};
    localparam logic [31:0] HLTW = {6'd22, 26'd0};

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_prog();
        for (int k = 0; k < 64; k++) prog[k] = HLTW;
    endtask

    task automatic restart();
        rst = 1'b1;
        cyc(2);
        rst = 1'b0;
    endtask

    task automatic step_io();
        cyc(5);
        step_pulse = 1'b1;
        cyc(1);
        step_pulse = 1'b0;
    endtask

    initial begin
        #(8ns * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clear_prog();
        cyc(2);
        // R1: state after reset
        check("R1", "pc after reset", {21'd0, imem_addr}, 32'd0);
        check("R1", "display after reset", disp_out, 32'd0);
        check("R1", "lamp after reset", {31'd0, sign_led}, 32'd0);

        // R2: ALU table
        for (int v = 0; v < NV; v++) begin
            clear_prog();
            prog[0] = ldi(1, int'(VEC[v].a));
            prog[1] = ldi(2, int'(VEC[v].b));
            prog[2] = enc(int'(VEC[v].op), 3, 1, 2, 0);
            prog[3] = enc(19, 0, 3, 0, 0);
            prog[4] = NOPW;
            restart();
            cyc(6);
            // R8: output pending, no step yet
            check("R8", "pc held on output", {21'd0, imem_addr}, 32'd3);
            check("R8", "display held", disp_out, 32'd0);
            step_pulse = 1'b1;
            cyc(1);
            step_pulse = 1'b0;
            check("R2", "alu result", disp_out, VEC[v].y);
            // R7: lamp follows bit 31
            check("R7", "lamp", {31'd0, sign_led}, {31'd0, VEC[v].y[31]});
            cyc(3);
            check("R11", "halt holds pc", {21'd0, imem_addr}, 32'd5);
        end

        // R1: reset clears display and registers
        restart();
        check("R1", "display cleared", disp_out, 32'd0);
        clear_prog();
        prog[0] = enc(19, 0, 3, 0, 0);
        prog[1] = NOPW;
        step_io();
        check("R1", "register cleared", disp_out, 32'd0);

        // R3: move writes [20:16], not [25:21]
        clear_prog();
        prog[0] = ldi(1, 'h12345);
        prog[1] = enc(14, 7, 9, 1, 0);
        prog[2] = enc(19, 0, 9, 0, 0);
        prog[3] = NOPW;
        prog[4] = enc(19, 0, 7, 0, 0);
        prog[5] = NOPW;
        restart();
        step_io();
        check("R3", "move target", disp_out, 32'h12345);
        step_io();
        check("R3", "move leaves rs", disp_out, 32'd0);

        // R4: store/load with address wrap through the register
        clear_prog();
        prog[0] = ldi(1, 'hABCDE);
        prog[1] = ldi(2, 2049);
        prog[2] = enc(16, 0, 1, 2, 0);
        prog[3] = ldi(2, 0);
        prog[4] = enc(15, 4, 0, 2, 1);
        prog[5] = enc(19, 0, 4, 0, 0);
        prog[6] = NOPW;
        restart();
        step_io();
        check("R4", "load after store wrap", disp_out, 32'hABCDE);

        // R4: wrap through the immediate
        clear_prog();
        prog[0] = ldi(1, 'h777);
        prog[1] = ldi(5, 2047);
        prog[2] = enc(16, 0, 1, 5, 3);
        prog[3] = enc(15, 6, 0, 0, 2);
        prog[4] = enc(19, 0, 6, 0, 0);
        prog[5] = NOPW;
        restart();
        step_io();
        check("R4", "immediate wrap", disp_out, 32'h777);

        // R5: zero extension of the long immediate
        clear_prog();
        prog[0] = ldi(1, 'h1FFFFF);
        prog[1] = enc(19, 0, 1, 0, 0);
        prog[2] = NOPW;
        restart();
        step_io();
        check("R5", "ldi zero extend", disp_out, 32'h001FFFFF);
        check("R5", "ldi lamp", {31'd0, sign_led}, 32'd0);

        // R6 / R8: input waits for step, samples switches at step
        clear_prog();
        prog[0] = enc(18, 6, 0, 0, 0);
        prog[1] = NOPW;
        prog[2] = enc(19, 0, 6, 0, 0);
        prog[3] = NOPW;
        sw_in = 11'h123;
        restart();
        cyc(5);
        check("R8", "pc held on input", {21'd0, imem_addr}, 32'd0);
        sw_in = 11'h5A5;
        step_pulse = 1'b1;
        cyc(1);
        step_pulse = 1'b0;
        step_io();
        check("R6", "switch value", disp_out, 32'h5A5);

        // R9: jump uses low 11 bits
        clear_prog();
        prog[0]  = ldi(7, 2058);
        prog[1]  = enc(20, 0, 7, 0, 0);
        prog[2]  = ldi(1, 1);
        prog[10] = ldi(1, 'h55);
        prog[11] = enc(19, 0, 1, 0, 0);
        prog[12] = NOPW;
        restart();
        step_io();
        check("R9", "jump target", disp_out, 32'h55);
        cyc(3);
        check("R9", "pc after jump", {21'd0, imem_addr}, 32'd13);

        // R10: branch taken
        clear_prog();
        prog[0]  = ldi(7, 20);
        prog[1]  = enc(21, 0, 7, 3, 0);
        prog[2]  = ldi(1, 'hBAD);
        prog[3]  = enc(19, 0, 1, 0, 0);
        prog[4]  = NOPW;
        prog[20] = ldi(1, 'h600D);
        prog[21] = enc(19, 0, 1, 0, 0);
        prog[22] = NOPW;
        restart();
        step_io();
        check("R10", "branch taken", disp_out, 32'h600D);

        // R10: branch not taken
        clear_prog();
        prog[0]  = ldi(7, 20);
        prog[1]  = ldi(3, 1);
        prog[2]  = enc(21, 0, 7, 3, 0);
        prog[3]  = ldi(1, 'h111);
        prog[4]  = enc(19, 0, 1, 0, 0);
        prog[5]  = NOPW;
        prog[20] = ldi(1, 'h222);
        prog[21] = enc(19, 0, 1, 0, 0);
        prog[22] = NOPW;
        restart();
        step_io();
        check("R10", "branch not taken", disp_out, 32'h111);

        // R11: undefined opcode acts as no-op, halt holds
        clear_prog();
        prog[0] = ldi(1, 'h33);
        prog[1] = {6'd40, 5'd1, 5'd2, 5'd3, 11'h7FF};
        prog[2] = enc(19, 0, 1, 0, 0);
        prog[3] = NOPW;
        restart();
        step_io();
        check("R11", "undefined opcode no write", disp_out, 32'h33);
        cyc(4);
        check("R11", "halt pc", {21'd0, imem_addr}, 32'd4);
        cyc(3);
        check("R11", "halt pc stays", {21'd0, imem_addr}, 32'd4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule